// File: doc/BRIEF.md
# Programmable Read Latency Pipeline

This block reproduces the read-data timing of a synchronous DRAM whose read latency is set through a mode register. A read command is registered together with its column offset and the full block of words the array returns for that burst. After the programmed number of clocks, the block drives those words out one per clock. A separate drive-enable output rises one clock ahead of the first valid word. The burst order is either sequential (wrapping) or interleaved, and it starts at the column offset given with the command.

The latency field accepts two or three clocks. Any other code is refused. A mode write that arrives while a read is anywhere in the pipeline is also refused. A new read that arrives while an older burst is still playing cuts the older burst short. The new data then follows back to back, at the same latency.

Internally, a three-stage command delay line feeds a burst player with two states. `PL_IDLE` moves to `PL_BURST` on a launch. `PL_BURST` stays in `PL_BURST` on a launch, which restarts the burst, or while beats remain. It returns to `PL_IDLE` after the last beat. The launch comes from delay stage one when the latency is two, and from delay stage two when it is three.

Top module: `rd_lat_pipe`

## Requirements
- R1: After reset, `dq_oe`, `dq_valid` and `cfg_rej` are low, `mode_lat` is 2 and `mode_ilv` is 0. `mode_lat` only ever holds 2 or 3.
- R2: A read registered at clock edge n with latency m makes `dq_valid` high, carrying its first beat, in the cycle that follows edge n+m.
- R3: `dq_oe` rises in the cycle after edge n+m-1, one cycle before `dq_valid`.
- R4: A burst delivers BL beats on consecutive cycles. `dq_oe` stays high whenever `dq_valid` is high.
- R5: `dq_oe` and `dq_valid` fall at the clock edge after the last beat, unless another burst follows with no gap.
- R6: With `mode_ilv`=0 (sequential), beat i outputs word number (col+i) mod BL, where word k is `rd_words[k*W +: W]`.
- R7: With `mode_ilv`=1 (interleaved), beat i outputs word number col XOR i.
- R8: A read at edge n' truncates any older burst. Its own first beat follows edge n'+m, with no empty cycle and no overlap.
- R9: A mode write with `cfg_lat` equal to 2 or 3, made while idle, updates `mode_lat` and `mode_ilv` at that edge. Reads issued afterwards use the new values.
- R10: A mode write with reserved `cfg_lat` 0 or 1 pulses `cfg_rej` for one cycle and leaves `mode_lat` and `mode_ilv` unchanged.
- R11: A mode write is refused (R10 behaviour) if any of these holds: `rd_cmd` is high in the same cycle, a read was registered within the three previous edges, or a beat is being output.
- R12: `dq_out` is all zeros whenever `dq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read command strobe |
| rd_col | input | $clog2(BL) | Starting column within the burst block |
| rd_words | input | BL*W | Block of words fetched for the burst |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_lat | input | 2 | Requested latency code (2 or 3 legal) |
| cfg_ilv | input | 1 | Requested burst type, 1 = interleaved |
| dq_oe | output | 1 | Output drive enable |
| dq_valid | output | 1 | Output data valid |
| dq_out | output | W | Output data beat |
| mode_lat | output | 2 | Active latency |
| mode_ilv | output | 1 | Active burst type |
| cfg_rej | output | 1 | One-cycle pulse for a refused mode write |

## Verification
The hardest state to reach is one where several reads are in the pipeline at once. A read can sit in a delay stage while an older burst is still mid-play, so the truncation point and the busy window for mode writes both come into play. Directed runs issue reads on consecutive cycles, reads exactly BL apart (seamless) and reads BL+1 apart (one idle cycle). They also place mode writes on the same edge as a read, two edges after one, and during a burst. A long pseudo-random stretch then mixes dense reads with occasional legal and reserved mode writes under both latencies. The behavioural model follows every cycle.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

    typedef enum logic [0:0] {
        PL_IDLE  = 1'b0,
        PL_BURST = 1'b1
    } play_st_t;

    localparam logic [1:0] LAT_TWO   = 2'd2;
    localparam logic [1:0] LAT_THREE = 2'd3;

    function automatic logic lat_code_ok(input logic [1:0] code);
        return (code == LAT_TWO) || (code == LAT_THREE);
    endfunction

    // Column fetched on beat idx; bl must be a power of two.
    function automatic int unsigned beat_col(input int unsigned start,
                                             input int unsigned idx,
                                             input logic        ilv,
                                             input int unsigned bl);
        if (ilv)
            return (start ^ idx) & (bl - 1);
        return (start + idx) & (bl - 1);
    endfunction

endpackage

// File: rtl/rlp_mode_reg.sv
module rlp_mode_reg #(
    parameter logic [1:0] RST_LAT = 2'd2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_lat,
    input  logic       cfg_ilv,
    input  logic       busy,
    output logic [1:0] mode_lat,
    output logic       mode_ilv,
    output logic       cfg_rej
);
    import rlp_pkg::*;

    logic accept;

    always_comb accept = cfg_we && lat_code_ok(cfg_lat) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_lat <= RST_LAT;
            mode_ilv <= 1'b0;
            cfg_rej  <= 1'b0;
        end else begin
            cfg_rej <= cfg_we && !accept;
            if (accept) begin
                mode_lat <= cfg_lat;
                mode_ilv <= cfg_ilv;
            end
        end
    end

endmodule

// File: rtl/rlp_delay_line.sv
module rlp_delay_line #(
    parameter int W     = 16,
    parameter int BL    = 4,
    parameter int CW    = 2,
    parameter int DEPTH = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_v,
    input  logic [CW-1:0]                   in_col,
    input  logic [BL*W-1:0]                 in_words,
    output logic [DEPTH-1:0]                stg_v,
    output logic [DEPTH-1:0][CW-1:0]        stg_col,
    output logic [DEPTH-1:0][BL*W-1:0]      stg_words
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic            src_v;
        logic [CW-1:0]   src_col;
        logic [BL*W-1:0] src_words;

        if (k == 0) begin : g_head
            always_comb begin
                src_v     = in_v;
                src_col   = in_col;
                src_words = in_words;
            end
        end else begin : g_tail
            always_comb begin
                src_v     = stg_v[k-1];
                src_col   = stg_col[k-1];
                src_words = stg_words[k-1];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_v[k]     <= 1'b0;
                stg_col[k]   <= '0;
                stg_words[k] <= '0;
            end else begin
                stg_v[k]     <= src_v;
                stg_col[k]   <= src_col;
                stg_words[k] <= src_words;
            end
        end
    end

endmodule

// File: rtl/rlp_burst_player.sv
module rlp_burst_player #(
    parameter int W  = 16,
    parameter int BL = 4,
    parameter int CW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [CW-1:0]   l_col,
    input  logic [BL*W-1:0] l_words,
    input  logic            l_ilv,
    output logic            pl_busy,
    output logic            dq_valid,
    output logic [W-1:0]    dq_out
);
    import rlp_pkg::*;

    localparam logic [CW-1:0] LAST_BEAT = CW'(BL - 1);

    play_st_t        st_q, st_d;
    logic [CW-1:0]   idx_q;
    logic [CW-1:0]   col_q;
    logic            ilv_q;
    logic [BL*W-1:0] words_q;
    logic [CW-1:0]   sel;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PL_IDLE:  st_d = launch ? PL_BURST : PL_IDLE;
            PL_BURST: begin
                if (launch)
                    st_d = PL_BURST;
                else if (idx_q == LAST_BEAT)
                    st_d = PL_IDLE;
                else
                    st_d = PL_BURST;
            end
            default:  st_d = PL_IDLE;
        endcase
    end

    // State register and burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= PL_IDLE;
            idx_q   <= '0;
            col_q   <= '0;
            ilv_q   <= 1'b0;
            words_q <= '0;
        end else begin
            st_q <= st_d;
            if (launch) begin
                idx_q   <= '0;
                col_q   <= l_col;
                ilv_q   <= l_ilv;
                words_q <= l_words;
            end else if (st_q == PL_BURST) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb sel = CW'(beat_col(32'(col_q), 32'(idx_q), ilv_q, BL));

    // Outputs
    always_comb begin
        pl_busy  = 1'b0;
        dq_valid = 1'b0;
        dq_out   = '0;
        unique case (st_q)
            PL_IDLE: ;
            PL_BURST: begin
                pl_busy  = 1'b1;
                dq_valid = 1'b1;
                dq_out   = words_q[int'(sel)*W +: W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe #(
    parameter int         W       = 16,
    parameter int         BL      = 4,
    parameter logic [1:0] RST_LAT = 2'd2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_cmd,
    input  logic [$clog2(BL)-1:0] rd_col,
    input  logic [BL*W-1:0]       rd_words,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_lat,
    input  logic                  cfg_ilv,
    output logic                  dq_oe,
    output logic                  dq_valid,
    output logic [W-1:0]          dq_out,
    output logic [1:0]            mode_lat,
    output logic                  mode_ilv,
    output logic                  cfg_rej
);
    import rlp_pkg::*;

    localparam int CW    = $clog2(BL);
    localparam int DEPTH = 3;

    logic [DEPTH-1:0]           stg_v;
    logic [DEPTH-1:0][CW-1:0]   stg_col;
    logic [DEPTH-1:0][BL*W-1:0] stg_words;
    logic                       pl_busy;
    logic                       busy;
    logic                       launch;
    logic [CW-1:0]              l_col;
    logic [BL*W-1:0]            l_words;

    always_comb busy = rd_cmd || (|stg_v) || pl_busy;

    rlp_mode_reg #(.RST_LAT(RST_LAT)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_lat  (cfg_lat),
        .cfg_ilv  (cfg_ilv),
        .busy     (busy),
        .mode_lat (mode_lat),
        .mode_ilv (mode_ilv),
        .cfg_rej  (cfg_rej)
    );

    rlp_delay_line #(.W(W), .BL(BL), .CW(CW), .DEPTH(DEPTH)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (rd_cmd),
        .in_col    (rd_col),
        .in_words  (rd_words),
        .stg_v     (stg_v),
        .stg_col   (stg_col),
        .stg_words (stg_words)
    );

    // Stage m-1 holds the read that launches on the next edge.
    always_comb begin
        if (mode_lat == LAT_THREE) begin
            launch  = stg_v[2];
            l_col   = stg_col[2];
            l_words = stg_words[2];
        end else begin
            launch  = stg_v[1];
            l_col   = stg_col[1];
            l_words = stg_words[1];
        end
    end

    rlp_burst_player #(.W(W), .BL(BL), .CW(CW)) u_play (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .l_col    (l_col),
        .l_words  (l_words),
        .l_ilv    (mode_ilv),
        .pl_busy  (pl_busy),
        .dq_valid (dq_valid),
        .dq_out   (dq_out)
    );

    // Drive leads data by one cycle: pending launch or active beat.
    always_comb dq_oe = dq_valid || launch;

endmodule

// File: rtl/rlp_chk.sv
module rlp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rd_cmd,
    input logic         cfg_we,
    input logic [1:0]   cfg_lat,
    input logic         dq_oe,
    input logic         dq_valid,
    input logic [W-1:0] dq_out,
    input logic [1:0]   mode_lat,
    input logic         cfg_rej
);

    // R1
    lat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lat == 2'd2) || (mode_lat == 2'd3));

    // R3
    oe_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_valid) |-> $past(dq_oe));

    // R4
    valid_in_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> dq_oe);

    // R12
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> (dq_out == '0));

    // R10
    reserved_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_lat < 2'd2)) |=> (cfg_rej && $stable(mode_lat)));

    // R11
    busy_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && rd_cmd) |=> cfg_rej);

endmodule

bind rd_lat_pipe rlp_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cmd   (rd_cmd),
    .cfg_we   (cfg_we),
    .cfg_lat  (cfg_lat),
    .dq_oe    (dq_oe),
    .dq_valid (dq_valid),
    .dq_out   (dq_out),
    .mode_lat (mode_lat),
    .cfg_rej  (cfg_rej)
);

// File: tb/sim_rd_lat_pipe.sv
module sim_rd_lat_pipe;
    localparam int W  = 16;
    localparam int BL = 4;
    localparam int CW = 2;
    localparam int NT = 4096;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_cmd = 1'b0;
    logic [CW-1:0]   rd_col = '0;
    logic [BL*W-1:0] rd_words = '0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_lat = 2'd0;
    logic            cfg_ilv = 1'b0;
    logic            dq_oe, dq_valid, mode_ilv, cfg_rej;
    logic [W-1:0]    dq_out;
    logic [1:0]      mode_lat;

    int n_cmp = 0;
    int n_bad = 0;
    int edge_n = 0;
    int last_rd = -100;
    int rid = 0;
    int m_lat = 2;
    int m_ilv = 0;
    int rej_exp = 0;
    bit done = 1'b0;
    bit exp_v [NT];
    logic [W-1:0] exp_d [NT];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    rd_lat_pipe #(.W(W), .BL(BL), .RST_LAT(2'd2)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_col(rd_col),
        .rd_words(rd_words), .cfg_we(cfg_we), .cfg_lat(cfg_lat),
        .cfg_ilv(cfg_ilv), .dq_oe(dq_oe), .dq_valid(dq_valid),
        .dq_out(dq_out), .mode_lat(mode_lat), .mode_ilv(mode_ilv),
        .cfg_rej(cfg_rej)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag, what, edge_n, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One clock: model update at the edge, compare at the falling edge.
    task automatic tick();
        int e;
        int c;
        bit busy;
        @(posedge clk);
        e = edge_n;
        rej_exp = 0;
        if (cfg_we) begin
            busy = rd_cmd || (last_rd >= e - 3) || (e > 0 && exp_v[e-1]);
            if ((cfg_lat == 2 || cfg_lat == 3) && !busy) begin
                m_lat = int'(cfg_lat);
                m_ilv = int'(cfg_ilv);
            end else begin
                rej_exp = 1;
            end
        end
        if (rd_cmd) begin
            for (int k = 0; k < BL + 4; k++) exp_v[e + m_lat + k] = 1'b0;
            for (int i = 0; i < BL; i++) begin
                c = (m_ilv != 0) ? (int'(rd_col) ^ i) : ((int'(rd_col) + i) % BL);
                exp_v[e + m_lat + i] = 1'b1;
                exp_d[e + m_lat + i] = rd_words[c*W +: W];
            end
            last_rd = e;
        end
        edge_n++;
        @(negedge clk);
        cmp("R2 R4 R5 R8", "dq_valid", int'(dq_valid), int'(exp_v[e]));
        cmp("R3 R5", "dq_oe", int'(dq_oe), int'(exp_v[e] || exp_v[e+1]));
        cmp(exp_v[e] ? "R6 R7 R8" : "R12", "dq_out", int'(dq_out),
            exp_v[e] ? int'(exp_d[e]) : 0);
        cmp("R10 R11", "cfg_rej", int'(cfg_rej), rej_exp);
        cmp("R1 R9", "mode_lat", int'(mode_lat), m_lat);
        cmp("R9 R10", "mode_ilv", int'(mode_ilv), m_ilv);
        rd_cmd = 1'b0;
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_read(input int col);
        rid++;
        for (int j = 0; j < BL; j++) rd_words[j*W +: W] = {8'(rid), 8'(j + 1)};
        rd_col = CW'(col);
        rd_cmd = 1'b1;
        tick();
    endtask

    task automatic wr(input int code, input int ilv);
        cfg_we  = 1'b1;
        cfg_lat = 2'(code);
        cfg_ilv = 1'(ilv);
        tick();
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", "reset dq_oe", int'(dq_oe), 0);
        cmp("R1", "reset dq_valid", int'(dq_valid), 0);
        cmp("R1", "reset cfg_rej", int'(cfg_rej), 0);
        cmp("R1", "reset mode_lat", int'(mode_lat), 2);
        cmp("R1", "reset mode_ilv", int'(mode_ilv), 0);
        rst_n = 1'b1;
        idle(2);
        // R2 R6 latency 2 sequential, several start columns
        do_read(0); idle(8);
        do_read(3); idle(8);
        do_read(1); idle(8);
        // R9 latency 3
        wr(3, 0); idle(2);
        do_read(2); idle(9);
        // R10 reserved codes
        wr(0, 1); idle(1);
        wr(1, 1); idle(1);
        // R7 interleaved with latency 3
        wr(3, 1); idle(2);
        do_read(2); idle(9);
        do_read(3); idle(9);
        // R11 writes while busy
        cfg_we = 1'b1; cfg_lat = 2'd2; cfg_ilv = 1'b0;
        do_read(1);
        idle(1); wr(2, 0);
        idle(2); wr(2, 0);
        idle(10);
        // R8 R5 truncation, seamless and gapped, latency 3
        do_read(0); do_read(1); do_read(2); idle(10);
        do_read(0); idle(3); do_read(1); idle(10);
        do_read(3); idle(4); do_read(2); idle(10);
        // Back to latency 2 sequential, repeat
        wr(2, 0); idle(2);
        do_read(0); do_read(3); idle(10);
        do_read(1); idle(3); do_read(2); idle(10);
        do_read(2); idle(4); do_read(0); idle(10);
        // Pseudo-random mix
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'hF) begin
                cfg_we = 1'b1; cfg_lat = lfsr[5:4]; cfg_ilv = lfsr[6];
            end
            if (lfsr[9:8] == 2'b00 || lfsr[9:7] == 3'b011) do_read(int'(lfsr[12:11]));
            else tick();
        end
        idle(12);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule